// File: doc/BRIEF.md
# Bidirectional Pin Port with Per-Pin Direction Control

The block manages a small group of chip pins, eight by default, through three registers reached over a register bus. The bus has an address, a write enable, write data and registered read data. A direction register chooses, pin by pin, whether the block drives the pin or listens to it. A level register has two uses. For a pin set to drive, it holds the value driven. For a pin set to listen, it selects between a pull-up and a floating pin. A third, read-only register returns the level actually seen on every pin, whatever its direction.

The pad controls (drive enable, drive value, pull-up enable) come from registers, one per pin. The incoming pin levels pass through a two-stage synchronizer before software can read them. The pin count is a parameter. A narrow build, such as a five-pin port, keeps the same register map and reads zero in the missing bit positions.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high and after it is released, both writable registers hold zero, every `pad_oe`, `pad_out` and `pad_pu` bit is 0, and `rd_data` is 0.
- R2: Address 0 is the direction register. A bit value of 1 makes the pin an output. In the clock cycle after the write takes effect, that pin's `pad_oe` is 1, its `pad_out` equals its bit in the level register, and its `pad_pu` is 0.
- R3: For a pin whose direction bit is 0, `pad_oe` and `pad_out` are 0. Its level-register bit (address 1) drives `pad_pu`: 1 turns the pull-up on, and 0 leaves the pin floating. The pad outputs lag the register update by one cycle.
- R4: Address 2 returns the synchronized level of every pin, for inputs and outputs alike. An output pin therefore reads back the level it drives.
- R5: A change on `pin_in` that is present before clock edge e shows in `rd_data` after edge e+2, provided `addr` stays at 2. After edge e+1, `rd_data` still shows the old level.
- R6: `rd_data` is registered. It shows the register selected by `addr` at the previous clock edge. Reads at addresses 0 and 1 return the last value written there, address 3 reads zero, and bits at position WIDTH and above read zero.
- R7: Writes to address 2 or address 3 change no register, no pad output and no read value.
- R8: With WIDTH set below the data width (for example 5), written bits at or above WIDTH are dropped. The port behaves as R2 to R6 describe on its WIDTH pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 direction, 1 level, 2 pin read, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the address of the previous cycle |
| pin_in | input | WIDTH | Raw pin levels from the pads |
| pad_oe | output | WIDTH | Per-pin drive enable |
| pad_out | output | WIDTH | Per-pin drive value |
| pad_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
The hardest case to reach is a listening pin whose level register changes, so that the pull-up switches while an external source may or may not be driving the pin. The pin level then depends on three things at once: the block's pad outputs, the external driver, and the floating default. The bench models the pads with a per-pin external driver that it can switch on and off. A floating pin reads as 0 in this model. Random writes to the direction and level registers are mixed with random changes to the external driver, so each pin passes through the driven, pulled-up, externally forced and floating states in many orders. The two-stage latency is measured directly with one directed edge placed just before a clock.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR = 2'd0,
    SEL_LVL = 2'd1,
    SEL_PIN = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      case (sel_e'(addr))
        SEL_DIR: dir_q <= wr_data[WIDTH-1:0];
        SEL_LVL: lvl_q <= wr_data[WIDTH-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_pad.sv
`timescale 1ns/1ps
module gpio_port_pad #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
        pad_pu[i]  <= 1'b0;
      end else begin
        pad_oe[i]  <= dir_q[i];
        pad_out[i] <= dir_q[i] & lvl_q[i];
        pad_pu[i]  <= ~dir_q[i] & lvl_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);
  localparam int SYNC_STAGES = 2;

  logic [WIDTH-1:0]  dir_q;
  logic [WIDTH-1:0]  lvl_q;
  logic [WIDTH-1:0]  pin_sync;
  logic [DATA_W-1:0] rd_next;

  gpio_port_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .dir_q(dir_q), .lvl_q(lvl_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .synced(pin_sync)
  );

  gpio_port_pad #(.WIDTH(WIDTH)) u_pad (
    .clk(clk), .rst(rst), .dir_q(dir_q), .lvl_q(lvl_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // Readback: narrow values are zero-extended to the bus width.
  always_comb begin
    rd_next = '0;
    case (sel_e'(addr))
      SEL_DIR: rd_next[WIDTH-1:0] = dir_q;
      SEL_LVL: rd_next[WIDTH-1:0] = lvl_q;
      SEL_PIN: rd_next[WIDTH-1:0] = pin_sync;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_pu,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  lvl_q,
  input logic [WIDTH-1:0]  pin_sync
);
  localparam logic [DATA_W-1:0] LIVE = DATA_W'((64'd1 << WIDTH) - 64'd1);

  assert_pads_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (rst)
    pad_oe == $past(dir_q));

  assert_no_drive_and_pull_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(pad_oe & pad_pu) == 0);

  assert_pull_from_level_R3: assert property (@(posedge clk) disable iff (rst)
    pad_pu == ($past(lvl_q) & ~$past(dir_q)));

  assert_pin_readback_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == 2'd2) |-> (rd_data[WIDTH-1:0] == $past(pin_sync)));

  assert_dir_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> (dir_q == $past(wr_data[WIDTH-1:0])));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE) == '0);

  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1]) |=> ($stable(dir_q) && $stable(lvl_q)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
  .dir_q(dir_q), .lvl_q(lvl_q), .pin_sync(pin_sync)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] pin_in;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic [7:0] ext_en = '0, ext_val = '0;

  logic [1:0] n_addr = '0;
  logic       n_wr_en = 1'b0;
  logic [7:0] n_wr_data = '0;
  logic [7:0] n_rd_data;
  logic [4:0] n_pin_in = '0;
  logic [4:0] n_oe, n_out, n_pu;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;
  logic [7:0] m_dir = '0, m_lvl = '0;

  always #2.5 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu)
  );

  gpio_port #(.WIDTH(5), .DATA_W(8)) u_gpio_port_narrow (
    .clk(clk), .rst(rst), .addr(n_addr), .wr_en(n_wr_en), .wr_data(n_wr_data),
    .rd_data(n_rd_data), .pin_in(n_pin_in), .pad_oe(n_oe), .pad_out(n_out),
    .pad_pu(n_pu)
  );

  // Pad model: block drive wins, then external drive, then pull-up; floating reads 0.
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (pad_oe[i])      pin_in[i] = pad_out[i];
      else if (ext_en[i]) pin_in[i] = ext_val[i];
      else                pin_in[i] = pad_pu[i];
    end
  end

  function automatic logic [7:0] exp_pin();
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      if (m_dir[i])       p[i] = m_lvl[i];
      else if (ext_en[i]) p[i] = ext_val[i];
      else                p[i] = m_lvl[i];
    end
    return p;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) m_dir = d;
    if (a == 2'd1) m_lvl = d;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_pads(input string req);
    check(req, "pad_oe", pad_oe, m_dir);
    check(req, "pad_out", pad_out, m_dir & m_lvl);
    check(req, "pad_pu", pad_pu, ~m_dir & m_lvl);
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    repeat (4) @(negedge clk);
    check_pads(req);
    do_read(2'd0, d); check(req, "dir read", d, m_dir);
    do_read(2'd1, d); check(req, "lvl read", d, m_lvl);
    do_read(2'd2, d); check(req, "pin read", d, exp_pin());
    do_read(2'd3, d); check(req, "addr3 read", d, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pad_oe", pad_oe, 8'h00);
    check("R1", "pad_pu", pad_pu, 8'h00);
    check("R1", "rd_data", rd_data, 8'h00);
    rst = 1'b0;
    check_all("R1");

    // R3: listening pins with pull-up pattern
    do_write(2'd1, 8'hA5);
    @(negedge clk);
    check_pads("R3");
    // R2: pad outputs lag the write by one cycle
    do_write(2'd0, 8'hF0);
    check("R2", "pad_oe before update", pad_oe, 8'h00);
    @(negedge clk);
    check("R2", "pad_oe after update", pad_oe, 8'hF0);
    check("R2", "pad_out after update", pad_out, 8'hA0);
    check("R3", "pad_pu after update", pad_pu, 8'h05);
    ext_en = 8'h3C; ext_val = 8'h14;
    check_all("R4");

    // R7: writes to pin and unused addresses are ignored
    do_write(2'd2, 8'h3C);
    do_write(2'd3, 8'hFF);
    check_all("R7");

    // R5: synchronizer latency
    do_write(2'd0, 8'h00);
    do_write(2'd1, 8'h00);
    ext_en = 8'hFF; ext_val = 8'h00;
    repeat (4) @(negedge clk);
    addr = 2'd2;
    repeat (3) @(negedge clk);
    ext_val = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    check("R5", "pin read after e+1", rd_data, 8'h00);
    @(negedge clk);
    check("R5", "pin read after e+2", rd_data, 8'h5A);

    // Random mix: R2 R3 R4 R6 R7
    for (int it = 0; it < 250; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: do_write(2'd0, 8'($urandom));
        1: do_write(2'd1, 8'($urandom));
        2: do_write(2'd2, 8'($urandom));
        3: do_write(2'd3, 8'($urandom));
        default: begin ext_en = 8'($urandom); ext_val = 8'($urandom); end
      endcase
      check_all("R6");
    end

    // R8: five-pin variant
    @(negedge clk);
    n_addr = 2'd0; n_wr_en = 1'b1; n_wr_data = 8'hFF;
    @(negedge clk);
    n_addr = 2'd1; n_wr_data = 8'hEA;
    @(negedge clk);
    n_wr_en = 1'b0; n_addr = 2'd0;
    @(negedge clk);
    check("R8", "narrow dir read", n_rd_data, 8'h1F);
    check("R8", "narrow pad_oe", n_oe, 5'h1F);
    check("R8", "narrow pad_out", n_out, 5'h0A);
    n_addr = 2'd1;
    @(negedge clk);
    check("R8", "narrow lvl read", n_rd_data, 8'h0A);
    n_pin_in = 5'h13; n_addr = 2'd2;
    repeat (4) @(negedge clk);
    check("R8", "narrow pin read", n_rd_data, 8'h13);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule